// File: doc/BRIEF.md
# UART Prioritized Interrupt Identification Unit

This block merges the interrupt conditions of a 16550-style serial port into a single interrupt line and a 4-bit identification code that software reads to learn which condition needs service. It owns an 8-bit interrupt enable register. It keeps sticky pending flags for receive-line errors, transmit-holding-empty and modem handshake changes. It counts character periods to detect a stalled receive FIFO. Data-ready follows the live receive level it is given.

The UART datapath around it supplies status levels, one-cycle event pulses and one-cycle register access strobes. Each source is cleared by the register access that services it. The identification code always names the highest-priority source that is both pending and enabled.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and after it is released with no stimulus, `ier_rdata` is 0x00, `irq` is 0 and `iir_id` is 4'b0001.
- R2: A write to the enable register stores `ier_wdata[3:0]`, and `ier_rdata` returns them on the following cycle with bits 7:4 reading 0. Bit 0 enables data-ready and timeout, bit 1 transmit-empty, bit 2 receive-line status, bit 3 handshake.
- R3: `iir_id` reports the first enabled, pending source in this order, with its code: line status 4'b0110, data ready 4'b0100, character timeout 4'b1100, transmit empty 4'b0010, handshake 4'b0000. With no enabled source pending it reports 4'b0001.
- R4: `irq` is 1 exactly when `iir_id` differs from 4'b0001. With enable bits 3:0 all zero, `irq` stays 0 whatever is pending.
- R5: A pulse on any bit of `line_err` sets line-status pending. The bits are overrun (bit 0), parity (bit 1), framing (bit 2) and break (bit 3). A pulse on `lsr_rd` clears it.
- R6: Data ready is the live level of `rx_ready` when `fifo_mode` is 0, and of `rx_at_trigger` when `fifo_mode` is 1.
- R7: Timeout is reported after 4 `char_tick` pulses while `fifo_mode` and `rx_nonempty` are both 1 and no `rx_push` or `rx_pop` occurs. Either strobe restarts the count, so an `rx_pop` removes the timeout.
- R8: When `fifo_mode` is 0, `iir_id[3]` is 0 and no timeout is reported.
- R9: Transmit-empty pending sets on a rising edge of `thr_empty`. It also sets when a register write takes enable bit 1 from 0 to 1 while `thr_empty` is 1. A `thr_wr` pulse clears it.
- R10: An `iir_rd` pulse clears transmit-empty pending only while `iir_id` is 4'b0010. Otherwise it leaves the flag unchanged.
- R11: A pulse on any bit of `modem_delta` sets handshake pending. The bits are CTS change, DSR change, RI trailing edge and DCD change. A pulse on `msr_rd` clears it.
- R12: When a line-status or handshake set event coincides with its clearing read, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| ier_rdata | output | 8 | Enable register read value |
| fifo_mode | input | 1 | FIFO mode enabled |
| iir_rd | input | 1 | Identification register read strobe |
| lsr_rd | input | 1 | Line status register read strobe |
| msr_rd | input | 1 | Handshake status register read strobe |
| thr_wr | input | 1 | Transmit holding register write strobe |
| rx_pop | input | 1 | Receive buffer read strobe |
| rx_push | input | 1 | Receive FIFO push strobe |
| line_err | input | 4 | Receive error event pulses |
| rx_ready | input | 1 | Receive data available level |
| rx_at_trigger | input | 1 | Receive FIFO at or above trigger level |
| rx_nonempty | input | 1 | Receive FIFO holds data |
| char_tick | input | 1 | One pulse per character period |
| thr_empty | input | 1 | Transmit holding register empty level |
| modem_delta | input | 4 | Handshake change event pulses |
| irq | output | 1 | Interrupt output |
| iir_id | output | 4 | Interrupt identification code |

## Verification
The assertions assume that strobes and event pulses last one cycle. They also assume `thr_empty` is held low through reset, so that no edge is seen on the first cycle. The bench drives every input on the falling clock edge as a single-cycle pulse or a held level, and keeps `thr_empty` low until after reset in every scenario. The sweep covers all enable nibbles against every combination of pending sources in both FIFO modes, resetting before each case so that no flag carries over.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  localparam int ID_W  = 4;
  localparam int EN_W  = 4;
  localparam int REG_W = 8;

  localparam logic [ID_W-1:0] ID_NONE = 4'b0001;
  localparam logic [ID_W-1:0] ID_LINE = 4'b0110;
  localparam logic [ID_W-1:0] ID_RDAT = 4'b0100;
  localparam logic [ID_W-1:0] ID_TOUT = 4'b1100;
  localparam logic [ID_W-1:0] ID_TXE  = 4'b0010;
  localparam logic [ID_W-1:0] ID_HSK  = 4'b0000;

  localparam int EN_RX  = 0;
  localparam int EN_TX  = 1;
  localparam int EN_LN  = 2;
  localparam int EN_HSK = 3;

  typedef struct packed {
    logic line;
    logic rdat;
    logic tout;
    logic txe;
    logic hsk;
  } uirq_src_t;
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int REG_W = 8,
  parameter int EN_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [EN_W-1:0]  en,
  output logic [EN_W-1:0]  en_rise,
  output logic [REG_W-1:0] rdata
);
  logic [EN_W-1:0] en_d;

  always_comb begin
    en_d    = en;
    en_rise = '0;
    if (wr) begin
      en_d    = wdata[EN_W-1:0];
      en_rise = wdata[EN_W-1:0] & ~en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en <= '0;
    else        en <= en_d;
  end

  assign rdata = {{(REG_W-EN_W){1'b0}}, en};

  assert_ier_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata == {{(REG_W-EN_W){1'b0}}, $past(wdata[EN_W-1:0])}));
endmodule

// File: rtl/uirq_sticky_flag.sv
module uirq_sticky_flag #(
  parameter bit SET_WINS = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_d;

  always_comb begin
    if (SET_WINS) q_d = set | (q & ~clr);
    else          q_d = ~clr & (set | q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_d;
  end

  assert_flag_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !q);
  assert_flag_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (set && (SET_WINS || !clr)) |=> q);
endmodule

// File: rtl/uirq_char_timeout.sv
module uirq_char_timeout #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic restart,
  input  logic tick,
  output logic expired
);
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt;
    if (!active || restart) begin
      cnt_en = (cnt != '0);
      cnt_d  = '0;
    end else if (tick && (cnt != CNT_MAX)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign expired = (cnt == CNT_MAX);

  assert_tout_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart || !active) |=> !expired);
  assert_tout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_MAX);
endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
  import uirq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  uirq_src_t       src,
  input  logic [EN_W-1:0] en,
  input  logic            fifo_mode,
  output logic [ID_W-1:0] id
);
  always_comb begin
    if      (src.line && en[EN_LN])             id = ID_LINE;
    else if (src.rdat && en[EN_RX])             id = ID_RDAT;
    else if (src.tout && en[EN_RX] && fifo_mode) id = ID_TOUT;
    else if (src.txe  && en[EN_TX])             id = ID_TXE;
    else if (src.hsk  && en[EN_HSK])            id = ID_HSK;
    else                                        id = ID_NONE;
  end

  assert_id_bit3_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_mode |-> !id[3]);
  assert_line_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (src.line && en[EN_LN]) |-> (id == ID_LINE));
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uirq_pkg::*;
#(
  parameter int TOUT_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ier_wr,
  input  logic [REG_W-1:0] ier_wdata,
  output logic [REG_W-1:0] ier_rdata,
  input  logic             fifo_mode,
  input  logic             iir_rd,
  input  logic             lsr_rd,
  input  logic             msr_rd,
  input  logic             thr_wr,
  input  logic             rx_pop,
  input  logic             rx_push,
  input  logic [3:0]       line_err,
  input  logic             rx_ready,
  input  logic             rx_at_trigger,
  input  logic             rx_nonempty,
  input  logic             char_tick,
  input  logic             thr_empty,
  input  logic [3:0]       modem_delta,
  output logic             irq,
  output logic [ID_W-1:0]  iir_id
);
  logic [EN_W-1:0] en, en_rise;
  logic            thr_empty_q;
  logic            txe_set, txe_clr;
  logic            tout_exp;
  uirq_src_t       src;

  uirq_enable_reg #(.REG_W(REG_W), .EN_W(EN_W)) u_ier (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(ier_wdata),
    .en(en), .en_rise(en_rise), .rdata(ier_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_empty_q <= 1'b0;
    else        thr_empty_q <= thr_empty;
  end

  uirq_sticky_flag #(.SET_WINS(1'b1)) u_line (
    .clk(clk), .rst_n(rst_n), .set(|line_err), .clr(lsr_rd), .q(src.line)
  );

  uirq_sticky_flag #(.SET_WINS(1'b1)) u_hsk (
    .clk(clk), .rst_n(rst_n), .set(|modem_delta), .clr(msr_rd), .q(src.hsk)
  );

  assign txe_set = (thr_empty & ~thr_empty_q) | (en_rise[EN_TX] & thr_empty);
  assign txe_clr = thr_wr | (iir_rd && (iir_id == ID_TXE));

  uirq_sticky_flag #(.SET_WINS(1'b0)) u_txe (
    .clk(clk), .rst_n(rst_n), .set(txe_set), .clr(txe_clr), .q(src.txe)
  );

  uirq_char_timeout #(.LIMIT(TOUT_CHARS)) u_tout (
    .clk(clk), .rst_n(rst_n), .active(fifo_mode & rx_nonempty),
    .restart(rx_push | rx_pop), .tick(char_tick), .expired(tout_exp)
  );

  assign src.tout = tout_exp;
  assign src.rdat = fifo_mode ? rx_at_trigger : rx_ready;

  uirq_prio_enc u_enc (
    .clk(clk), .rst_n(rst_n), .src(src), .en(en), .fifo_mode(fifo_mode), .id(iir_id)
  );

  assign irq = (src.line & en[EN_LN]) | (src.rdat & en[EN_RX]) |
               (src.tout & en[EN_RX] & fifo_mode) | (src.txe & en[EN_TX]) |
               (src.hsk & en[EN_HSK]);

  assert_irq_vs_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (iir_id != ID_NONE));
  assert_txe_write_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    thr_wr |=> !src.txe);
  assert_txe_iir_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (src.txe && iir_rd && (iir_id != ID_TXE) && !thr_wr) |=> src.txe);
endmodule

// File: tb/tb_uart_irq_ident.sv
`timescale 1ns/1ps
module tb_uart_irq_ident;
  logic clk = 1'b0;
  logic rst_n;
  logic ier_wr; logic [7:0] ier_wdata; logic [7:0] ier_rdata;
  logic fifo_mode, iir_rd, lsr_rd, msr_rd, thr_wr, rx_pop, rx_push;
  logic [3:0] line_err; logic rx_ready, rx_at_trigger, rx_nonempty, char_tick, thr_empty;
  logic [3:0] modem_delta; logic irq; logic [3:0] iir_id;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  uart_irq_ident dut (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
    .fifo_mode(fifo_mode), .iir_rd(iir_rd), .lsr_rd(lsr_rd), .msr_rd(msr_rd), .thr_wr(thr_wr),
    .rx_pop(rx_pop), .rx_push(rx_push), .line_err(line_err), .rx_ready(rx_ready),
    .rx_at_trigger(rx_at_trigger), .rx_nonempty(rx_nonempty), .char_tick(char_tick),
    .thr_empty(thr_empty), .modem_delta(modem_delta), .irq(irq), .iir_id(iir_id)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ier_wr = 0; ier_wdata = 0; iir_rd = 0; lsr_rd = 0; msr_rd = 0; thr_wr = 0;
    rx_pop = 0; rx_push = 0; line_err = 0; char_tick = 0; modem_delta = 0;
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    fifo_mode = 0; rx_ready = 0; rx_at_trigger = 0; rx_nonempty = 0; thr_empty = 0;
    rst_n = 0;
    cyc();
    rst_n = 1;
  endtask

  task automatic wr_ier(input logic [7:0] v);
    ier_wr = 1; ier_wdata = v; cyc(); ier_wr = 0; ier_wdata = 0;
  endtask

  function automatic logic [3:0] exp_id(input bit f, input logic [3:0] en,
      input bit ln, input bit rd, input bit to, input bit tx, input bit hs);
    if (en[2] && ln)            return 4'b0110;
    else if (en[0] && rd)       return 4'b0100;
    else if (en[0] && to && f)  return 4'b1100;
    else if (en[1] && tx)       return 4'b0010;
    else if (en[3] && hs)       return 4'b0000;
    else                        return 4'b0001;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle_inputs();
    fifo_mode = 0; rx_ready = 0; rx_at_trigger = 0; rx_nonempty = 0; thr_empty = 0;
    repeat (3) cyc();
    chk("R1 rdata in reset", ier_rdata, 8'h00);
    chk("R1 id in reset", iir_id, 4'b0001);
    rst_n = 1; cyc();
    chk("R1 irq after reset", irq, 0);
    chk("R1 id after reset", iir_id, 4'b0001);

    // R2 enable register: upper bits read zero
    wr_ier(8'hFF);
    chk("R2 rdata FF", ier_rdata, 8'h0F);
    wr_ier(8'hA5);
    chk("R2 rdata A5", ier_rdata, 8'h05);

    // Sweep for R3 R4 R6 R8: every enable nibble against every pending set
    for (int f = 0; f < 2; f++)
      for (int en = 0; en < 16; en++)
        for (int m = 0; m < 32; m++) begin
          logic [3:0] e;
          do_reset();
          fifo_mode = f[0];
          wr_ier({4'hC, en[3:0]});
          rx_ready = m[1]; rx_at_trigger = m[1];
          rx_nonempty = m[2];
          if (m[0]) line_err = 4'b0001 << (m % 4);
          if (m[4]) modem_delta = 4'b1000 >> (en % 4);
          if (m[3]) thr_empty = 1;
          cyc(); line_err = 0; modem_delta = 0;
          if (m[2]) for (int t = 0; t < 4; t++) begin char_tick = 1; cyc(); char_tick = 0; end
          e = exp_id(f[0], en[3:0], m[0], m[1], m[2], m[3], m[4]);
          chk("R3 sweep id", iir_id, e);
          chk("R4 sweep irq", irq, e != 4'b0001);
          if (!f[0]) chk("R8 bit3 low", iir_id[3], 0);
        end

    // R6 data ready source selection by mode
    do_reset(); wr_ier(8'h01);
    rx_at_trigger = 1; cyc();
    chk("R6 trigger ignored w/o fifo", iir_id, 4'b0001);
    rx_ready = 1; cyc();
    chk("R6 ready in byte mode", iir_id, 4'b0100);
    fifo_mode = 1; rx_at_trigger = 0; cyc();
    chk("R6 ready ignored in fifo", iir_id, 4'b0001);
    rx_at_trigger = 1; cyc();
    chk("R6 trigger in fifo", iir_id, 4'b0100);

    // R5 each error bit sets, status read clears
    for (int b = 0; b < 4; b++) begin
      do_reset(); wr_ier(8'h04);
      line_err = 4'b0001 << b; cyc(); line_err = 0;
      chk("R5 err bit sets", iir_id, 4'b0110);
      lsr_rd = 1; cyc(); lsr_rd = 0;
      chk("R5 status read clears", iir_id, 4'b0001);
    end

    // R11 each handshake bit sets, read clears
    for (int b = 0; b < 4; b++) begin
      do_reset(); wr_ier(8'h08);
      modem_delta = 4'b0001 << b; cyc(); modem_delta = 0;
      chk("R11 delta sets", irq, 1);
      chk("R11 id", iir_id, 4'b0000);
      msr_rd = 1; cyc(); msr_rd = 0;
      chk("R11 read clears", iir_id, 4'b0001);
    end

    // R12 set and clear in the same cycle
    do_reset(); wr_ier(8'h0C);
    line_err = 4'b0100; lsr_rd = 1; cyc(); line_err = 0; lsr_rd = 0;
    chk("R12 line set wins", iir_id, 4'b0110);
    lsr_rd = 1; cyc(); lsr_rd = 0;
    modem_delta = 4'b0010; msr_rd = 1; cyc(); modem_delta = 0; msr_rd = 0;
    chk("R12 hsk set wins", iir_id, 4'b0000);

    // R7 timeout counting, restart by push, clear by pop
    do_reset(); fifo_mode = 1; wr_ier(8'h01); rx_nonempty = 1;
    for (int t = 0; t < 3; t++) begin char_tick = 1; cyc(); char_tick = 0; end
    chk("R7 three ticks no timeout", iir_id, 4'b0001);
    rx_push = 1; cyc(); rx_push = 0;
    for (int t = 0; t < 3; t++) begin char_tick = 1; cyc(); char_tick = 0; end
    chk("R7 push restarted count", iir_id, 4'b0001);
    char_tick = 1; cyc(); char_tick = 0;
    chk("R7 timeout after four", iir_id, 4'b1100);
    rx_pop = 1; cyc(); rx_pop = 0;
    chk("R7 pop clears timeout", iir_id, 4'b0001);

    // R8 timeout never reported outside fifo mode
    do_reset(); wr_ier(8'h01); rx_nonempty = 1;
    for (int t = 0; t < 6; t++) begin char_tick = 1; cyc(); char_tick = 0; end
    chk("R8 no timeout byte mode", iir_id, 4'b0001);

    // R9 edge set, enable-rise set, write clear; R10 read clear
    do_reset(); wr_ier(8'h02);
    thr_empty = 1; cyc();
    chk("R9 rising edge sets", iir_id, 4'b0010);
    iir_rd = 1; cyc(); iir_rd = 0;
    chk("R10 id read clears txe", iir_id, 4'b0001);
    wr_ier(8'h02);
    chk("R9 no set without enable rise", iir_id, 4'b0001);
    wr_ier(8'h00); wr_ier(8'h02);
    chk("R9 enable rise sets", iir_id, 4'b0010);
    thr_wr = 1; thr_empty = 0; cyc(); thr_wr = 0;
    chk("R9 write clears", iir_id, 4'b0001);

    do_reset(); wr_ier(8'h06);
    thr_empty = 1; line_err = 4'b1000; cyc(); line_err = 0;
    chk("R10 line shown first", iir_id, 4'b0110);
    iir_rd = 1; cyc(); iir_rd = 0;
    lsr_rd = 1; cyc(); lsr_rd = 0;
    chk("R10 txe kept when not shown", iir_id, 4'b0010);
    iir_rd = 1; cyc(); iir_rd = 0;
    chk("R10 txe cleared when shown", iir_id, 4'b0001);

    // R4 all enables off
    do_reset(); rx_ready = 1; thr_empty = 1; line_err = 4'hF; modem_delta = 4'hF; cyc();
    line_err = 0; modem_delta = 0; cyc();
    chk("R4 disabled irq", irq, 0);
    chk("R4 disabled id", iir_id, 4'b0001);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule